// File: doc/BRIEF.md
# Supply Level Monitor Flag

This block keeps the status of a supply level monitor. Outside it, a bank of analog comparators reports, one bit per trigger level, whether the supply is under that level. Each bit arrives here as a raw digital input. The block first passes those bits through a synchronizer. It then selects the one bit named by a software-programmed level code and keeps a sticky-free status flag that follows it. When the flag is set and an interrupt enable is on, the block raises an interrupt request.

Software reaches the block through a single control/status byte, with a plain write strobe and a combinational read. The flag has three ways to clear:
- an explicit software write of zero to its bit;
- any write that changes the level code;
- hardware clearing, as soon as the selected level no longer reports a low supply.

Level code 0 turns the monitor off.

Top module: `supply_mon`

## Requirements
- R1: After reset the read byte is 0x00 and irq is low.
- R2: Byte layout: bits [2:0] hold the level code, bit 6 holds the interrupt enable and bit 7 holds the flag. Bits 5:3 always read zero. Reads are combinational from the current state.
- R3: Each raw level input passes through two synchronizer flops. A change on a raw input is visible on the flag after the third rising clock edge, and not after the second.
- R4: With a level code c from 1 to 7, the flag becomes 1 when synchronized input bit c-1 is 1.
- R5: The flag returns to 0 on its own once synchronized input bit c-1 is back to 0.
- R6: Level code 0 disables the monitor. The flag stays 0 and irq stays low for every input pattern.
- R7: irq is high exactly when the flag and the interrupt enable are both 1.
- R8: A write with bit 7 at 0 clears the flag at that clock edge. If the selected level still reports a low supply, the flag sets again at the next edge.
- R9: Writing 1 to bit 7 never sets the flag and never clears it.
- R10: A write that changes the level code clears the flag at that edge. At the following edge the flag reflects the input bit of the new level.
- R11: A write that keeps the same level code and has bit 7 at 1 leaves a set flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| below_raw | input | 7 | Raw per-level indications; bit i is 1 when the supply is under level i+1 |
| wr_en | input | 1 | Write strobe for the control/status byte |
| wr_data | input | 8 | Byte being written |
| rd_data | output | 8 | Current control/status byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default three-bit level code. That gives seven levels and 128 input patterns, so it can sweep every pattern under every one of the eight codes. For each pair it checks the flag, the irq and the read byte against values computed arithmetically, with the enable toggled across the sweep. Directed sequences then cover the synchronizer latency and the three clearing paths at the exact edges where each one acts.

// File: rtl/svlm_pkg.sv
package svlm_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
endpackage

// File: rtl/svlm_sync.sv
module svlm_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/svlm_ctrl.sv
module svlm_ctrl
  import svlm_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [SEL_W-1:0] sel_q,
  output logic             ie_q,
  output logic             lvl_change,
  output logic             sw_clear
);
  logic [SEL_W-1:0] new_sel;
  assign new_sel = wr_data[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      ie_q  <= 1'b0;
    end else if (wr_en) begin
      sel_q <= new_sel;
      ie_q  <= wr_data[IE_BIT];
    end
  end

  // Event strobes for the flag: a code change, and a write of zero to the flag bit.
  assign lvl_change = wr_en && (new_sel != sel_q);
  assign sw_clear   = wr_en && !wr_data[FLAG_BIT];

  p_write_holds_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sel_q == $past(new_sel)));
endmodule

// File: rtl/svlm_level_pick.sv
module svlm_level_pick #(
  parameter int SEL_W = 3,
  parameter int NLVL  = 7
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NLVL-1:0]  below_s,
  output logic             hit
);
  logic [NLVL:0] padded;
  // Code 0 indexes a constant zero, so the monitor is off there.
  assign padded = {below_s, 1'b0};
  assign hit    = padded[sel];
endmodule

// File: rtl/svlm_flag.sv
module svlm_flag #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             lvl_change,
  input  logic             sw_clear,
  input  logic [SEL_W-1:0] sel_q,
  output logic             flag_q
);
  logic flag_d;

  always_comb begin
    if (lvl_change || sw_clear) flag_d = 1'b0;
    else                        flag_d = hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  p_level_change_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_change |=> !flag_q);
  p_sw_write_zero_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> !flag_q);
  p_auto_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !flag_q);
  p_set_when_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !lvl_change && !sw_clear) |=> flag_q);
  p_disabled_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |-> !flag_q);
endmodule

// File: rtl/supply_mon.sv
module supply_mon
  import svlm_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NLVL       = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLVL-1:0]  below_raw,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  logic [NLVL-1:0]  below_s;
  logic [SEL_W-1:0] sel_q;
  logic             ie_q, lvl_change, sw_clear, hit, flag_q;

  svlm_sync #(.W(NLVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(below_raw), .q(below_s));

  svlm_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .sel_q(sel_q), .ie_q(ie_q), .lvl_change(lvl_change), .sw_clear(sw_clear));

  svlm_level_pick #(.SEL_W(SEL_W), .NLVL(NLVL)) u_pick (
    .sel(sel_q), .below_s(below_s), .hit(hit));

  svlm_flag #(.SEL_W(SEL_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .lvl_change(lvl_change),
    .sw_clear(sw_clear), .sel_q(sel_q), .flag_q(flag_q));

  always_comb begin
    rd_data                = '0;
    rd_data[SEL_W-1:0]     = sel_q;
    rd_data[IE_BIT]        = ie_q;
    rd_data[FLAG_BIT]      = flag_q;
  end

  assign irq = flag_q & ie_q;

  p_irq_needs_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sel_q != '0));
  p_irq_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !irq);
endmodule

// File: tb/supply_mon_test.sv
module supply_mon_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] below_raw = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  supply_mon uut (.clk(clk), .rst_n(rst_n), .below_raw(below_raw),
                  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    idle(1);

    // R2: unused bits read zero even when written with ones
    write_reg(8'h7B);
    chk("R2 layout", rd_data, 8'h43);

    // R3: synchronizer latency, level 3 with enable
    write_reg(8'h43);
    below_raw = 7'b0000100;
    idle(2);
    chk("R3 not after two edges", rd_data[7], 0);
    idle(1);
    chk("R3 after three edges", rd_data[7], 1);
    chk("R7 irq with flag and enable", irq, 1);

    // R11: same code, bit 7 one keeps flag
    write_reg(8'hC3);
    chk("R11 flag kept", rd_data[7], 1);

    // R8: write zero clears, sets again next edge
    write_reg(8'h43);
    chk("R8 cleared", rd_data[7], 0);
    idle(1);
    chk("R8 sets again", rd_data[7], 1);

    // R10: change code to 5 while level 5 below
    below_raw = 7'b1111111;
    idle(3);
    write_reg(8'hC5);
    chk("R10 cleared on change", rd_data[7], 0);
    idle(1);
    chk("R10 new level reflected", rd_data[7], 1);

    // R5: auto clear
    below_raw = 7'b0000000;
    idle(3);
    chk("R5 auto clear", rd_data[7], 0);
    chk("R7 irq low", irq, 0);

    // R9: writing one to flag bit does not set it
    write_reg(8'hC5);
    chk("R9 no set", rd_data, 8'h45);
    idle(1);
    chk("R9 still clear", rd_data[7], 0);

    // Exhaustive sweep: R4 R6 R7 R2
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 128; p++) begin
        logic ie, f;
        ie = ((p + s) % 3) == 0;
        below_raw = p[6:0];
        write_reg({1'b0, ie, 3'b000, s[2:0]});
        idle(2);
        f = (s != 0) && p[s-1];
        chk(s == 0 ? "R6 disabled flag" : "R4 flag", rd_data[7], f);
        chk("R7 irq", irq, f & ie);
        chk("R2 fields", rd_data[6:0], {ie, 3'b000, s[2:0]});
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule